// File: doc/BRIEF.md
# Product-Term Logic Tile

This tile is a small piece of programmable logic. It takes 18 logic inputs: most come from a shared routing bus and a few come from dedicated input pins. It produces four outputs, and all four are driven back onto the routing bus so that other tiles can use them.

A set of 20 product terms forms the AND plane. Each term can use any input as a true literal, as a complemented literal, or not at all. Each output has its own stage after the AND plane:

- It ORs a chosen subset of the product terms.
- It can XOR that sum with one further product term that it selects.
- It presents the result either directly (combinational) or through a D flip-flop.

Each output flip-flop updates on the tile clock only when the global clock line chosen for that output is active. There are three such lines.

Configuration is held in 24 words and is written through a plain parallel port while the config-enable pin is high. Outputs are guaranteed only after config-enable drops. Every pin is a plain level signal with no handshake and no back-pressure. A configuration write always completes in the cycle it is presented, and the logic inputs are sampled continuously.

Top module: `pterm_tile`

## Requirements
- R1: Logic input i is `route_i[i]` for i in 0..15, and input 16+j is `ded_i[j]` for j in 0..1.
- R2: Term words are at addresses 0..19, with one word per term. Bits [2i+1:2i] of a term word set input i's literal: 00 means the input is not used, 01 means true, 10 means complemented, and 11 forces the term to 0.
- R3: A product term whose literal fields are all 00 evaluates to 1.
- R4: An output whose OR mask is empty and whose XOR stage is off reads 0.
- R5: Output words are at addresses 20..23, one for each of outputs 0..3. In an output word, bits [19:0] select the terms to OR, and the output equals the OR of the selected terms.
- R6: In an output word, bit 20 enables the XOR stage and bits [25:21] pick the term to XOR with. An index of 20 or above XORs with constant 0.
- R7: With bit 26 of the output word at 0, the output follows the inputs within the same cycle.
- R8: With bit 26 at 1, the output is a register. It loads the logic value at a clock edge only when `gclk_en_i[sel]` is high, where sel is bits [28:27] of the output word. Otherwise it holds. A sel value of 3 never loads.
- R9: Synchronous reset clears all configuration words and all output registers.
- R10: A configuration word is written at a clock edge only while `cfg_en_i` is high. A write attempted with `cfg_en_i` low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tile clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cfg_en_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 5 | Configuration word address |
| cfg_data_i | input | 36 | Configuration word data |
| gclk_en_i | input | 3 | Global clock line activity, one bit per line |
| route_i | input | 16 | Inputs from the shared routing bus |
| ded_i | input | 2 | Dedicated input pins |
| out_o | output | 4 | Tile outputs, fed back to the routing bus |

## Verification
The AND plane is exercised with three kinds of term: an all-unused term, terms mixing true and complemented literals that span both routing and dedicated inputs, and a term carrying a forcing 11 field. Together these separate a correct literal decode from inverted or swapped encodings. The OR stage is driven with input patterns that make each selected term true on its own and then neither, which distinguishes OR from AND or from a single-term pass. The XOR stage is tested with a valid index under both values of that term and with an out-of-range index. Registered outputs are clocked with the selected line idle, with other lines active, with the selected line active, and with a selector of 3, which shows whether the enable is tied to the right line.

// File: rtl/pterm_pkg.sv
package pterm_pkg;
  typedef enum logic [1:0] {
    LIT_UNUSED = 2'b00,
    LIT_TRUE   = 2'b01,
    LIT_INV    = 2'b10,
    LIT_KILL   = 2'b11
  } lit_e;
endpackage

// File: rtl/pterm_and_plane.sv
module pterm_and_plane #(
  parameter int N_IN   = 18,
  parameter int N_TERM = 20,
  localparam int TW    = 2 * N_IN
) (
  input  logic [N_IN-1:0]        in_i,
  input  logic [N_TERM*TW-1:0]   cfg_i,
  output logic [N_TERM-1:0]      term_o
);
  import pterm_pkg::*;

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [N_IN-1:0] hit;
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      lit_e code;
      assign code = lit_e'(cfg_i[t*TW + 2*i +: 2]);
      always_comb begin
        unique case (code)
          LIT_UNUSED: hit[i] = 1'b1;
          LIT_TRUE:   hit[i] = in_i[i];
          LIT_INV:    hit[i] = ~in_i[i];
          default:    hit[i] = 1'b0;
        endcase
      end
    end
    assign term_o[t] = &hit;
  end
endmodule

// File: rtl/pterm_out_cell.sv
module pterm_out_cell #(
  parameter int N_TERM = 20,
  parameter int N_CLK  = 3,
  localparam int IDX_W = $clog2(N_TERM),
  localparam int SEL_W = $clog2(N_CLK + 1)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [N_TERM-1:0] term_i,
  input  logic [N_TERM-1:0] or_mask_i,
  input  logic              xor_en_i,
  input  logic [IDX_W-1:0]  xor_idx_i,
  input  logic              reg_mode_i,
  input  logic [SEL_W-1:0]  clk_sel_i,
  input  logic [N_CLK-1:0]  gclk_en_i,
  output logic              y_o
);
  logic sum, xor_bit, d, tick, q;

  assign sum = |(term_i & or_mask_i);

  always_comb begin
    xor_bit = 1'b0;
    if (xor_en_i && int'(xor_idx_i) < N_TERM) xor_bit = term_i[xor_idx_i];
  end

  assign d = sum ^ xor_bit;

  always_comb begin
    tick = 1'b0;
    if (int'(clk_sel_i) < N_CLK) tick = gclk_en_i[clk_sel_i];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)     q <= 1'b0;
    else if (tick) q <= d;
  end

  assign y_o = reg_mode_i ? q : d;

  assert_reg_load_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    tick |=> q == $past(d));
  assert_reg_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !tick |=> $stable(q));
  assert_reg_reset_R9: assert property (@(posedge clk_i)
    rst_i |=> q == 1'b0);
endmodule

// File: rtl/pterm_tile.sv
module pterm_tile #(
  parameter int N_ROUTE = 16,
  parameter int N_DED   = 2,
  parameter int N_TERM  = 20,
  parameter int N_OUT   = 4,
  parameter int N_CLK   = 3,
  localparam int N_IN   = N_ROUTE + N_DED,
  localparam int CFG_W  = 2 * N_IN,
  localparam int ADDR_W = $clog2(N_TERM + N_OUT),
  localparam int OSEL_W = $clog2(N_OUT),
  localparam int IDX_W  = $clog2(N_TERM),
  localparam int SEL_W  = $clog2(N_CLK + 1),
  localparam int XEN_B  = N_TERM,
  localparam int IDX_B  = N_TERM + 1,
  localparam int REG_B  = IDX_B + IDX_W,
  localparam int SEL_B  = REG_B + 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cfg_en_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [CFG_W-1:0]  cfg_data_i,
  input  logic [N_CLK-1:0]  gclk_en_i,
  input  logic [N_ROUTE-1:0] route_i,
  input  logic [N_DED-1:0]  ded_i,
  output logic [N_OUT-1:0]  out_o
);
  logic [CFG_W-1:0]        term_cfg [N_TERM];
  logic [CFG_W-1:0]        out_cfg  [N_OUT];
  logic [N_TERM*CFG_W-1:0] term_flat;
  logic [N_IN-1:0]         in_vec;
  logic [N_TERM-1:0]       terms;
  logic [ADDR_W-1:0]       oaddr;

  assign in_vec = {ded_i, route_i};
  assign oaddr  = cfg_addr_i - ADDR_W'(N_TERM);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int t = 0; t < N_TERM; t++) term_cfg[t] <= '0;
      for (int o = 0; o < N_OUT; o++)  out_cfg[o]  <= '0;
    end else if (cfg_en_i) begin
      if (int'(cfg_addr_i) < N_TERM)
        term_cfg[cfg_addr_i] <= cfg_data_i;
      else if (int'(cfg_addr_i) < N_TERM + N_OUT)
        out_cfg[oaddr[OSEL_W-1:0]] <= cfg_data_i;
    end
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_flat
    assign term_flat[t*CFG_W +: CFG_W] = term_cfg[t];
  end

  pterm_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .in_i(in_vec), .cfg_i(term_flat), .term_o(terms)
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    pterm_out_cell #(.N_TERM(N_TERM), .N_CLK(N_CLK)) u_cell (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .term_i    (terms),
      .or_mask_i (out_cfg[o][N_TERM-1:0]),
      .xor_en_i  (out_cfg[o][XEN_B]),
      .xor_idx_i (out_cfg[o][IDX_B +: IDX_W]),
      .reg_mode_i(out_cfg[o][REG_B]),
      .clk_sel_i (out_cfg[o][SEL_B +: SEL_W]),
      .gclk_en_i (gclk_en_i),
      .y_o       (out_o[o])
    );
  end

  assert_cfg_write_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (cfg_en_i && int'(cfg_addr_i) < N_TERM) |=> term_cfg[$past(cfg_addr_i)] == $past(cfg_data_i));
  assert_cfg_hold_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    !cfg_en_i |=> $stable(term_flat));
  assert_cfg_reset_R9: assert property (@(posedge clk_i)
    rst_i |=> term_flat == '0);
endmodule

// File: tb/tb_pterm_tile.sv
module tb_pterm_tile;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_en;
  logic [4:0]  cfg_addr;
  logic [35:0] cfg_data;
  logic [2:0]  gclk_en;
  logic [15:0] route;
  logic [1:0]  ded;
  logic [3:0]  out;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pterm_tile dut (
    .clk_i(clk), .rst_i(rst), .cfg_en_i(cfg_en), .cfg_addr_i(cfg_addr),
    .cfg_data_i(cfg_data), .gclk_en_i(gclk_en), .route_i(route),
    .ded_i(ded), .out_o(out)
  );

  function automatic logic [35:0] lit(int i, logic [1:0] c);
    logic [35:0] w = '0;
    w[2*i +: 2] = c;
    return w;
  endfunction

  function automatic logic [35:0] outw(logic [19:0] mask, logic xen,
                                       logic [4:0] idx, logic rg, logic [1:0] sel);
    return {7'b0, sel, rg, idx, xen, mask};
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [4:0] a, logic [35:0] d, logic en = 1'b1);
    @(negedge clk);
    cfg_en = en; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_en = 1'b0;
  endtask

  task automatic drive(logic [15:0] r, logic [1:0] d);
    route = r; ded = d;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    drive(16'hFFFF, 2'b11);
    for (int k = 0; k < 4; k++) check("R9/R4 reset output", out[k], 1'b0);
  endtask

  task automatic t_all_unused();
    cfg_write(5'd20, outw(20'h1, 0, 0, 0, 0));
    drive(16'h0000, 2'b00); check("R3 unused term", out[0], 1'b1);
    drive(16'hFFFF, 2'b11); check("R3 unused term", out[0], 1'b1);
  endtask

  task automatic t_literals();
    cfg_write(5'd1, lit(3, 2'b01) | lit(17, 2'b10));
    cfg_write(5'd21, outw(20'h2, 0, 0, 0, 0));
    drive(16'h0008, 2'b00); check("R2/R7 true+inv", out[1], 1'b1);
    drive(16'h0008, 2'b10); check("R1/R2 ded1 inverted", out[1], 1'b0);
    drive(16'h0000, 2'b00); check("R2 true literal low", out[1], 1'b0);
    cfg_write(5'd2, lit(16, 2'b01));
    cfg_write(5'd22, outw(20'h4, 0, 0, 0, 0));
    drive(16'h0000, 2'b01); check("R1 ded0 as input16", out[2], 1'b1);
    drive(16'h0000, 2'b10); check("R1 ded1 not input16", out[2], 1'b0);
    cfg_write(5'd2, lit(16, 2'b01) | lit(0, 2'b11));
    drive(16'h0001, 2'b01); check("R2 kill field", out[2], 1'b0);
  endtask

  task automatic t_or();
    cfg_write(5'd3, lit(0, 2'b01));
    cfg_write(5'd20, outw(20'hA, 0, 0, 0, 0));
    drive(16'h0001, 2'b00); check("R5 term3 alone", out[0], 1'b1);
    drive(16'h0008, 2'b00); check("R5 term1 alone", out[0], 1'b1);
    drive(16'h0000, 2'b00); check("R5 neither", out[0], 1'b0);
  endtask

  task automatic t_xor();
    cfg_write(5'd23, outw(20'h1, 1, 5'd1, 0, 0));
    drive(16'h0008, 2'b00); check("R6 xor term high", out[3], 1'b0);
    drive(16'h0000, 2'b00); check("R6 xor term low", out[3], 1'b1);
    cfg_write(5'd23, outw(20'h1, 1, 5'd31, 0, 0));
    drive(16'h0008, 2'b00); check("R6 xor index out of range", out[3], 1'b1);
    check("R5 out0 untouched", out[0], 1'b1);
  endtask

  task automatic t_register();
    cfg_write(5'd21, outw(20'h2, 0, 0, 1, 2'd1));
    @(negedge clk); drive(16'h0008, 2'b00); gclk_en = 3'b101;
    @(negedge clk); #1; check("R8 other lines only", out[1], 1'b0);
    gclk_en = 3'b010;
    @(negedge clk); #1; check("R8 selected line loads", out[1], 1'b1);
    drive(16'h0000, 2'b00); check("R8 no comb path", out[1], 1'b1);
    gclk_en = 3'b000;
    @(negedge clk); #1; check("R8 hold when idle", out[1], 1'b1);
    gclk_en = 3'b010;
    @(negedge clk); #1; check("R8 loads zero", out[1], 1'b0);
    cfg_write(5'd21, outw(20'h2, 0, 0, 1, 2'd3));
    drive(16'h0008, 2'b00); gclk_en = 3'b111;
    @(negedge clk); #1; check("R8 sel 3 never loads", out[1], 1'b0);
    gclk_en = 3'b000;
  endtask

  task automatic t_cfg_gate();
    cfg_write(5'd20, 36'h0, 1'b0);
    drive(16'h0001, 2'b00); check("R10 write ignored", out[0], 1'b1);
    cfg_write(5'd20, 36'h0, 1'b1);
    drive(16'h0001, 2'b00); check("R10 write taken", out[0], 1'b0);
  endtask

  task automatic t_reset_clears();
    cfg_write(5'd20, outw(20'h1, 0, 0, 0, 0));
    drive(16'h0000, 2'b00); check("R9 precondition", out[0], 1'b1);
    do_reset();
    drive(16'hFFFF, 2'b11);
    for (int k = 0; k < 4; k++) check("R9 config cleared", out[k], 1'b0);
  endtask

  initial begin
    rst = 1'b1; cfg_en = 1'b0; cfg_addr = '0; cfg_data = '0;
    gclk_en = '0; route = '0; ded = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_all_unused();
    t_literals();
    t_or();
    t_xor();
    t_register();
    t_cfg_gate();
    t_reset_clears();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule